// File: doc/BRIEF.md
# BT.656 Byte-Stream Video Formatter

This block turns a stream of YUV 4:2:2 pixel pairs into the 8-bit serial byte stream used by BT.656 video receivers. It sends one byte on every rising edge of the video clock. At the nominal 27 MHz byte rate this gives 13.5 Mpixel/s. Each line opens with an end-of-active-video timing code. A run of blanking samples follows, then a start-of-active-video timing code, then the active samples. Vertical and field timing is carried only in the flag bits of those codes. The block drives no separate retrace or sync lines.

The formatter counts lines through a 525-line frame made of two interlaced fields. It raises the field and vertical-blanking flags according to the line number. Pixel pairs come from an upstream buffer through a valid/ready handshake. If no pair is ready when one is needed, the formatter sends black and flags an underrun. Two configuration inputs set the number of blanking sample groups and the number of active pixel pairs per line. Both are expected to stay constant while a frame is running.

Top module: `vid656_tx`

## Requirements
- R1: While `rst_ni` is low, `byte_o` is 10h, `line_o` is 1, `underrun_o` is 0 and `pair_ready_o` is 0. The first byte after reset is the first byte of line 1.
- R2: A line is exactly 8 + 4·(`cfg_blank_i` + `cfg_act_i`) bytes long. It is made of a 4-byte end code, then 4·`cfg_blank_i` blanking bytes, then a 4-byte start code, then 4·`cfg_act_i` active bytes. A blanking count of zero is allowed.
- R3: Each timing code is the four bytes FF, 00, 00, XY. XY is built as bit7=1, bit6=F, bit5=V, bit4=H, bit3=V^H, bit2=F^H, bit1=F^V, bit0=F^V^H. H is 1 in the end code and 0 in the start code.
- R4: Each active 4-byte group carries one pixel pair, in the order U, Y0, V, Y1. `pair_ready_o` is high exactly in the cycle before the U byte is sent, and a pair is taken only when `pair_valid_i` is also high in that cycle. Pair data offered in any other cycle has no effect on the output.
- R5: An active sample of 00h is sent as 01h, and an active sample of FFh is sent as FEh. All other sample values pass unchanged.
- R6: The F flag is 0 on lines 4 to 265 and 1 on all other lines, that is lines 266 to 525 and lines 1 to 3.
- R7: The V flag is 1 on lines 1 to 19 and on lines 264 to 282, and 0 on all other lines.
- R8: `line_o` gives the line number (1 to 525) of the byte currently on `byte_o`. It changes only when a new line's first FF byte appears, and it wraps from 525 to 1.
- R9: If `pair_valid_i` is low in a cycle where `pair_ready_o` is high, the whole 4-byte group is sent as black (U=V=80h, Y=10h). `underrun_o` is then high exactly while that group's U byte is on `byte_o`.
- R10: Blanking bytes alternate 80h and 10h, starting with 80h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Video byte clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_blank_i | input | 12 | Blanking length per line, in 4-byte groups |
| cfg_act_i | input | 12 | Active length per line, in pixel pairs (at least 1) |
| pair_valid_i | input | 1 | Upstream pixel pair available |
| pair_ready_o | output | 1 | Formatter takes a pair this cycle |
| pair_u_i | input | 8 | Cb sample, co-sited with Y0 |
| pair_y0_i | input | 8 | First luma sample |
| pair_v_i | input | 8 | Cr sample, co-sited with Y0 |
| pair_y1_i | input | 8 | Second luma sample |
| byte_o | output | 8 | Output byte stream |
| underrun_o | output | 1 | Black pair sent in place of missing data |
| line_o | output | 10 | Line number of the byte on `byte_o` |

## Verification
Some properties hold on every cycle, and the assertions check those:
- every FF byte is followed by two zero bytes and then a protected XY word;
- the F and V bits in that word match `line_o`;
- active bytes never carry 00h or FFh;
- a pair that is taken appears as the next U byte, and an underrun U byte is black;
- `line_o` stays in range and changes only at an FF byte.

Other behaviour needs the bench's scenarios. These include the exact line length for a given blanking and active count, including zero blanking. They also include the positions of the blanking bytes, the Y0/V/Y1 bytes of a pair, black for a whole pair on underrun, data ignored outside ready, and the sweep of all 525 lines through the field and blanking boundaries and the wrap back to line 1.

// File: rtl/vid656_pkg.sv
package vid656_pkg;
  typedef enum logic [1:0] {PH_EAV, PH_BLANK, PH_SAV, PH_ACT} phase_e;

  localparam logic [7:0] BLK_C = 8'h80;
  localparam logic [7:0] BLK_Y = 8'h10;

  function automatic logic [7:0] clip_sample(input logic [7:0] s);
    if (s == 8'h00) return 8'h01;
    if (s == 8'hFF) return 8'hFE;
    return s;
  endfunction

  function automatic logic [7:0] trs_word(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction
endpackage

// File: rtl/vid656_timing.sv
module vid656_timing
  import vid656_pkg::*;
#(
  parameter int LINES = 525,
  parameter int CFG_W = 12,
  localparam int LW = $clog2(LINES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] cfg_blank_i,
  input  logic [CFG_W-1:0] cfg_act_i,
  output phase_e           phase_o,
  output logic [1:0]       bi_o,
  output logic [LW-1:0]    line_o
);
  phase_e           phase_q;
  logic [1:0]       bi_q;
  logic [CFG_W-1:0] grp_q;
  logic [LW-1:0]    line_q;
  logic [CFG_W:0]   grp_nx;
  logic             blank_last, act_last;

  assign grp_nx     = {1'b0, grp_q} + {{CFG_W{1'b0}}, 1'b1};
  assign blank_last = grp_nx >= {1'b0, cfg_blank_i};
  assign act_last   = grp_nx >= {1'b0, cfg_act_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_EAV;
      bi_q    <= '0;
      grp_q   <= '0;
      line_q  <= LW'(1);
    end else begin
      bi_q <= bi_q + 2'd1;
      if (bi_q == 2'd3) begin
        unique case (phase_q)
          PH_EAV: begin
            grp_q   <= '0;
            phase_q <= (cfg_blank_i == '0) ? PH_SAV : PH_BLANK;
          end
          PH_BLANK: begin
            if (blank_last) phase_q <= PH_SAV;
            else            grp_q   <= grp_nx[CFG_W-1:0];
          end
          PH_SAV: begin
            grp_q   <= '0;
            phase_q <= PH_ACT;
          end
          default: begin
            if (act_last) begin
              phase_q <= PH_EAV;
              line_q  <= (line_q == LW'(LINES)) ? LW'(1) : line_q + LW'(1);
            end else begin
              grp_q <= grp_nx[CFG_W-1:0];
            end
          end
        endcase
      end
    end
  end

  assign phase_o = phase_q;
  assign bi_o    = bi_q;
  assign line_o  = line_q;
endmodule

// File: rtl/vid656_flags.sv
module vid656_flags #(
  parameter int LINES = 525,
  parameter int F_LO  = 4,
  parameter int F_HI  = 265,
  parameter int V0_HI = 19,
  parameter int V1_LO = 264,
  parameter int V1_HI = 282,
  localparam int LW = $clog2(LINES + 1)
) (
  input  logic [LW-1:0] line_i,
  output logic          f_o,
  output logic          v_o
);
  assign f_o = !((line_i >= LW'(F_LO)) && (line_i <= LW'(F_HI)));
  assign v_o = (line_i <= LW'(V0_HI)) ||
               ((line_i >= LW'(V1_LO)) && (line_i <= LW'(V1_HI)));
endmodule

// File: rtl/vid656_dp.sv
module vid656_dp
  import vid656_pkg::*;
#(
  parameter int LINES = 525,
  localparam int LW = $clog2(LINES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  phase_e        phase_i,
  input  logic [1:0]    bi_i,
  input  logic [LW-1:0] line_i,
  input  logic          f_i,
  input  logic          v_i,
  input  logic          valid_i,
  input  logic [7:0]    u_i,
  input  logic [7:0]    y0_i,
  input  logic [7:0]    v_samp_i,
  input  logic [7:0]    y1_i,
  output logic          ready_o,
  output logic [7:0]    byte_o,
  output logic          underrun_o,
  output logic [LW-1:0] line_o
);
  logic [7:0]    byte_d, byte_q, hy0_q, hv_q, hy1_q;
  logic          hold_ok_q, under_q, take;
  logic [LW-1:0] line_q;

  assign ready_o = (phase_i == PH_ACT) && (bi_i == 2'd0);
  assign take    = ready_o && valid_i;

  always_comb begin
    byte_d = BLK_Y;
    unique case (phase_i)
      PH_EAV, PH_SAV: begin
        unique case (bi_i)
          2'd0:       byte_d = 8'hFF;
          2'd1, 2'd2: byte_d = 8'h00;
          default:    byte_d = trs_word(f_i, v_i, phase_i == PH_EAV);
        endcase
      end
      PH_BLANK: byte_d = bi_i[0] ? BLK_Y : BLK_C;
      default: begin
        unique case (bi_i)
          2'd0:    byte_d = take ? clip_sample(u_i) : BLK_C;
          2'd1:    byte_d = hold_ok_q ? hy0_q : BLK_Y;
          2'd2:    byte_d = hold_ok_q ? hv_q : BLK_C;
          default: byte_d = hold_ok_q ? hy1_q : BLK_Y;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_q    <= BLK_Y;
      under_q   <= 1'b0;
      line_q    <= LW'(1);
      hold_ok_q <= 1'b0;
      hy0_q     <= '0;
      hv_q      <= '0;
      hy1_q     <= '0;
    end else begin
      byte_q  <= byte_d;
      under_q <= ready_o && !valid_i;
      line_q  <= line_i;
      if (take) begin
        hold_ok_q <= 1'b1;
        hy0_q     <= clip_sample(y0_i);
        hv_q      <= clip_sample(v_samp_i);
        hy1_q     <= clip_sample(y1_i);
      end else if (ready_o) begin
        hold_ok_q <= 1'b0;
      end
    end
  end

  assign byte_o     = byte_q;
  assign underrun_o = under_q;
  assign line_o     = line_q;
endmodule

// File: rtl/vid656_tx.sv
module vid656_tx
  import vid656_pkg::*;
#(
  parameter int LINES = 525,
  parameter int CFG_W = 12,
  parameter int F_LO  = 4,
  parameter int F_HI  = 265,
  parameter int V0_HI = 19,
  parameter int V1_LO = 264,
  parameter int V1_HI = 282,
  localparam int LW = $clog2(LINES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] cfg_blank_i,
  input  logic [CFG_W-1:0] cfg_act_i,
  input  logic             pair_valid_i,
  output logic             pair_ready_o,
  input  logic [7:0]       pair_u_i,
  input  logic [7:0]       pair_y0_i,
  input  logic [7:0]       pair_v_i,
  input  logic [7:0]       pair_y1_i,
  output logic [7:0]       byte_o,
  output logic             underrun_o,
  output logic [LW-1:0]    line_o
);
  phase_e        phase_w;
  logic [1:0]    bi_w;
  logic [LW-1:0] tline_w;
  logic          f_w, v_w;

  vid656_timing #(.LINES(LINES), .CFG_W(CFG_W)) u_tmg (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cfg_blank_i(cfg_blank_i), .cfg_act_i(cfg_act_i),
    .phase_o(phase_w), .bi_o(bi_w), .line_o(tline_w)
  );

  vid656_flags #(
    .LINES(LINES), .F_LO(F_LO), .F_HI(F_HI),
    .V0_HI(V0_HI), .V1_LO(V1_LO), .V1_HI(V1_HI)
  ) u_flg (
    .line_i(tline_w), .f_o(f_w), .v_o(v_w)
  );

  vid656_dp #(.LINES(LINES)) u_dp (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .phase_i(phase_w), .bi_i(bi_w), .line_i(tline_w),
    .f_i(f_w), .v_i(v_w),
    .valid_i(pair_valid_i), .u_i(pair_u_i), .y0_i(pair_y0_i),
    .v_samp_i(pair_v_i), .y1_i(pair_y1_i),
    .ready_o(pair_ready_o), .byte_o(byte_o),
    .underrun_o(underrun_o), .line_o(line_o)
  );
endmodule

// File: rtl/vid656_tx_chk.sv
module vid656_tx_chk
  import vid656_pkg::*;
#(
  parameter int LINES = 525,
  parameter int F_LO  = 4,
  parameter int F_HI  = 265,
  parameter int V0_HI = 19,
  parameter int V1_LO = 264,
  parameter int V1_HI = 282,
  localparam int LW = $clog2(LINES + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [7:0]    byte_o,
  input logic          underrun_o,
  input logic [LW-1:0] line_o,
  input logic          pair_ready_o,
  input logic          pair_valid_i,
  input logic [7:0]    pair_u_i,
  input phase_e        phase_i
);
  logic exp_f, exp_v;
  assign exp_f = !((line_o >= LW'(F_LO)) && (line_o <= LW'(F_HI)));
  assign exp_v = (line_o <= LW'(V0_HI)) ||
                 ((line_o >= LW'(V1_LO)) && (line_o <= LW'(V1_HI)));

  AST_TRS_ZEROS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_o == 8'hFF |=> (byte_o == 8'h00) ##1 (byte_o == 8'h00)); // R3

  AST_TRS_PROT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_o == 8'hFF |-> ##3 (byte_o[7] && byte_o[3] == (byte_o[5] ^ byte_o[4]) &&
      byte_o[2] == (byte_o[6] ^ byte_o[4]) && byte_o[1] == (byte_o[6] ^ byte_o[5]) &&
      byte_o[0] == (byte_o[6] ^ byte_o[5] ^ byte_o[4]))); // R3

  AST_F_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_o == 8'hFF |-> ##3 (byte_o[6] == exp_f)); // R6

  AST_V_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_o == 8'hFF |-> ##3 (byte_o[5] == exp_v)); // R7

  AST_ACT_CLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(phase_i) == PH_ACT |-> (byte_o != 8'h00 && byte_o != 8'hFF)); // R5

  AST_TAKE_U: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_ready_o && pair_valid_i |=> byte_o == clip_sample($past(pair_u_i))); // R4

  AST_UNDERRUN_BLACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |-> byte_o == BLK_C); // R9

  AST_LINE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_o >= LW'(1) && line_o <= LW'(LINES)); // R8

  AST_LINE_AT_TRS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_o != $past(line_o) |-> byte_o == 8'hFF); // R8
endmodule

bind vid656_tx vid656_tx_chk #(
  .LINES(LINES), .F_LO(F_LO), .F_HI(F_HI),
  .V0_HI(V0_HI), .V1_LO(V1_LO), .V1_HI(V1_HI)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .byte_o(byte_o), .underrun_o(underrun_o),
  .line_o(line_o), .pair_ready_o(pair_ready_o), .pair_valid_i(pair_valid_i),
  .pair_u_i(pair_u_i), .phase_i(phase_w)
);

// File: tb/sim_vid656_tx.sv
`timescale 1ns/1ps
module sim_vid656_tx;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] cfg_blank_i = 12'd1;
  logic [11:0] cfg_act_i = 12'd2;
  logic        pair_valid_i = 1'b0;
  logic        pair_ready_o;
  logic [7:0]  pair_u_i = '0, pair_y0_i = '0, pair_v_i = '0, pair_y1_i = '0;
  logic [7:0]  byte_o;
  logic        underrun_o;
  logic [9:0]  line_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  vid656_tx u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_blank_i(cfg_blank_i), .cfg_act_i(cfg_act_i),
    .pair_valid_i(pair_valid_i), .pair_ready_o(pair_ready_o),
    .pair_u_i(pair_u_i), .pair_y0_i(pair_y0_i), .pair_v_i(pair_v_i), .pair_y1_i(pair_y1_i),
    .byte_o(byte_o), .underrun_o(underrun_o), .line_o(line_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] dgen(int ln, int p, int k);
    return 8'((ln * 5 + p * 67 + k * 29) & 255);
  endfunction

  function automatic logic [7:0] clipv(logic [7:0] s);
    return (s == 8'h00) ? 8'h01 : (s == 8'hFF) ? 8'hFE : s;
  endfunction

  function automatic bit is_raw_edge(logic [7:0] s);
    return s == 8'h00 || s == 8'hFF;
  endfunction

  task automatic run_cfg(input int nb, input int na, input int nlines, input int gap_mod);
    int ln;
    int len;
    int act0;
    logic [7:0] pu, py0, pv, py1;
    bit pok;
    rst_ni = 1'b0;
    pair_valid_i = 1'b0;
    cfg_blank_i = 12'(nb);
    cfg_act_i = 12'(na);
    repeat (3) @(negedge clk_i);
    chk(byte_o == 8'h10, "R1 byte", byte_o, 8'h10);
    chk(line_o == 10'd1, "R1 line", line_o, 1);
    chk(underrun_o == 1'b0, "R1 underrun", underrun_o, 0);
    chk(pair_ready_o == 1'b0, "R1 ready", pair_ready_o, 0);
    rst_ni = 1'b1;
    ln = 1;
    len = 8 + 4 * (nb + na);
    act0 = 8 + 4 * nb;
    pu = '0; py0 = '0; pv = '0; py1 = '0; pok = 0;
    for (int li = 0; li < nlines; li++) begin
      for (int pos = 0; pos < len; pos++) begin
        logic [7:0] exp_b;
        bit ef, ev, eu;
        int p;
        p = (pos - act0) / 4;
        // drive for upcoming byte
        if (pos >= act0 && ((pos - act0) % 4) == 0) begin
          pok = !((ln % gap_mod) == 2 && p == (ln % na));
          pu = dgen(ln, p, 0); py0 = dgen(ln, p, 1);
          pv = dgen(ln, p, 2); py1 = dgen(ln, p, 3);
          pair_valid_i = pok;
          pair_u_i = pu; pair_y0_i = py0; pair_v_i = pv; pair_y1_i = py1;
          chk(pair_ready_o == 1'b1, "R4 ready high", pair_ready_o, 1);
        end else begin
          // R4: data offered outside ready must be ignored
          pair_valid_i = (pos % 3) == 0;
          pair_u_i = 8'h00; pair_y0_i = 8'hFF; pair_v_i = 8'h00; pair_y1_i = 8'hFF;
          chk(pair_ready_o == 1'b0, "R4 ready low", pair_ready_o, 0);
        end
        @(negedge clk_i);
        ef = !(ln >= 4 && ln <= 265);
        ev = (ln <= 19) || (ln >= 264 && ln <= 282);
        eu = 0;
        if (pos < 4 || (pos >= act0 - 4 && pos < act0)) begin
          int q;
          bit h;
          q = (pos < 4) ? pos : pos - (act0 - 4);
          h = pos < 4;
          exp_b = (q == 0) ? 8'hFF : (q < 3) ? 8'h00 :
                  {1'b1, ef, ev, h, ev ^ h, ef ^ h, ef ^ ev, ef ^ ev ^ h};
          if (pos == 0) chk(byte_o == exp_b, "R2 line start", byte_o, exp_b);
          else chk(byte_o == exp_b, "R3 code byte", byte_o, exp_b);
          if (q == 3) begin
            chk(byte_o[6] == ef, "R6 F flag", byte_o[6], ef);
            chk(byte_o[5] == ev, "R7 V flag", byte_o[5], ev);
          end
        end else if (pos < act0) begin
          exp_b = (pos % 2 == 0) ? 8'h80 : 8'h10;
          chk(byte_o == exp_b, "R10 blank", byte_o, exp_b);
        end else begin
          int k;
          logic [7:0] raw;
          k = (pos - act0) % 4;
          raw = (k == 0) ? pu : (k == 1) ? py0 : (k == 2) ? pv : py1;
          if (pok) begin
            exp_b = clipv(raw);
            if (is_raw_edge(raw)) chk(byte_o == exp_b, "R5 clip", byte_o, exp_b);
            else chk(byte_o == exp_b, "R4 pair order", byte_o, exp_b);
          end else begin
            exp_b = (k[0] == 1'b0) ? 8'h80 : 8'h10;
            eu = (k == 0);
            chk(byte_o == exp_b, "R9 black", byte_o, exp_b);
          end
        end
        chk(underrun_o == eu, "R9 underrun flag", underrun_o, eu);
        chk(line_o == 10'(ln), "R8 line", line_o, ln);
      end
      ln = (ln == 525) ? 1 : ln + 1;
    end
  endtask

  initial begin
    run_cfg(1, 2, 527, 6);
    run_cfg(0, 3, 4, 2);
    run_cfg(2, 1, 3, 3);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (60000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule